// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM of 32,768 bytes. The host issues one access at a time through a valid/ready handshake. Each access carries a 15-bit word address, a write flag and, for writes, one data byte. The controller registers the request. It then drives the memory's active-low chip enable, write enable and output enable in a fixed, legal order, and it holds address and write data steady for the whole access. The memory data bus is split into an output byte, an input byte and an enable for the external tri-state driver.

Two programmable clock counts set the timing, and both are sampled when a request is accepted. The cycle count N sets the minimum length of a strobe phase for reads and writes. The output-enable count K sets how long the controller waits after output enable falls before it samples read data. A count of zero is treated as one. Between accesses the memory is held in standby with chip enable high. Every access opens with one setup clock in which neither the memory nor the controller drives the bus. A read that is followed by a write therefore always gets a turnaround clock with output enable high before the controller's driver turns on.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and req_ready is 1.
- R2: A request is accepted on a rising clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the access ends. The address, write flag, write data and both counts are captured at acceptance, and later changes on those inputs do not affect the access in progress. No new access starts while req_valid is 0.
- R3: Every access begins with exactly one setup clock with mem_ce_n=0, mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0.
- R4: A write (req_write=1) follows setup with Neff clocks of mem_we_n=0 and mem_dq_oe=1, where Neff is cfg_cycle, or 1 when cfg_cycle is 0. One hold clock follows with mem_we_n=1, mem_dq_oe=1 and mem_ce_n=0, and then the controller goes idle. The write therefore commits on the rising edge of mem_we_n, with data still driven.
- R5: A read (req_write=0) follows setup with L clocks of mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0, and then the controller goes idle. L is the larger of Neff and Keff, where Keff is cfg_oe, or 1 when cfg_oe is 0.
- R6: rd_data takes the value on mem_dq_in during the Keff-th clock with mem_oe_n=0. rd_valid is 1 for exactly the one clock after that clock.
- R7: mem_we_n and mem_oe_n are never 0 together. mem_dq_oe is 1 only while mem_oe_n is 1. mem_dq_oe turns on only when mem_oe_n was already 1 on the previous clock.
- R8: mem_addr and mem_dq_out do not change while mem_ce_n stays 0. At the rising edge of mem_we_n during a write, both are unchanged and the driver is on.
- R9: With the default HOLD_IDLE_ADDR=1, mem_addr keeps the last access's address while idle. With HOLD_IDLE_ADDR=0 it reads zero while mem_ce_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (15) | Word address |
| req_wdata | input | DATA_W (8) | Write data |
| cfg_cycle | input | CNT_W (6) | Strobe phase count N in clocks |
| cfg_oe | input | CNT_W (6) | Output-enable-to-sample count K in clocks |
| rd_valid | output | 1 | One-clock pulse marking new read data |
| rd_data | output | DATA_W (8) | Captured read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W (15) | Memory address bus |
| mem_dq_out | output | DATA_W (8) | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the external data driver |
| mem_dq_in | input | DATA_W (8) | Data from the memory |

## Verification
The hardest case to reach is the exact sampling clock of R6. A memory that returns constant data cannot tell a capture one clock early from a capture one clock late. The bench's memory model therefore mixes a counter of clocks since output enable fell into the byte it returns, so each sampling clock yields a different value. The reads also use settings where Keff is below, equal to and above Neff; in the last case capture coincides with the final clock of the read. A read is followed at once by a write so that the driver-enable ordering of R7 is exercised. Request inputs and counts are changed while an access is in progress to show they are ignored.

// File: rtl/asram_pkg.sv
package asram_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_WPULSE = 3'd2,
      PH_WHOLD  = 3'd3,
      PH_RPULSE = 3'd4
   } asram_phase_e;

   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic dq_oe;
      logic ready;
   } asram_strobe_t;

   function automatic asram_strobe_t strobe_of(asram_phase_e ph);
      asram_strobe_t s;
      s = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, ready: 1'b0};
      case (ph)
         PH_IDLE:   s.ready = 1'b1;
         PH_SETUP:  s.ce_n  = 1'b0;
         PH_WPULSE: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.dq_oe = 1'b1; end
         PH_WHOLD:  begin s.ce_n = 1'b0; s.dq_oe = 1'b1; end
         PH_RPULSE: begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
         default:   s.ready = 1'b1;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   output logic [CNT_W-1:0] elapsed
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     elapsed <= '0;
      else if (start) elapsed <= ONE;
      else if (run)   elapsed <= elapsed + ONE;
   end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             write_q,
   input  logic [CNT_W-1:0] n_q,
   input  logic [CNT_W-1:0] k_q,
   input  logic [CNT_W-1:0] l_q,
   input  logic [CNT_W-1:0] elapsed,
   output logic             accept,
   output logic             tmr_start,
   output logic             tmr_run,
   output logic             capture,
   output logic             ce_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             dq_oe,
   output logic             ready
);
   asram_phase_e  ph_q, ph_d;
   asram_strobe_t strb_d;

   assign accept = req_valid && ready;

   always_comb begin
      ph_d      = ph_q;
      tmr_start = 1'b0;
      tmr_run   = 1'b0;
      case (ph_q)
         PH_IDLE:   if (accept) ph_d = PH_SETUP;
         PH_SETUP:  begin
            tmr_start = 1'b1;
            ph_d      = write_q ? PH_WPULSE : PH_RPULSE;
         end
         PH_WPULSE: begin
            tmr_run = 1'b1;
            if (elapsed == n_q) ph_d = PH_WHOLD;
         end
         PH_WHOLD:  ph_d = PH_IDLE;
         PH_RPULSE: begin
            tmr_run = 1'b1;
            if (elapsed == l_q) ph_d = PH_IDLE;
         end
         default:   ph_d = PH_IDLE;
      endcase
   end

   assign capture = (ph_q == PH_RPULSE) && (elapsed == k_q);
   assign strb_d  = strobe_of(ph_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         ce_n  <= 1'b1;
         we_n  <= 1'b1;
         oe_n  <= 1'b1;
         dq_oe <= 1'b0;
         ready <= 1'b1;
      end else begin
         ph_q  <= ph_d;
         ce_n  <= strb_d.ce_n;
         we_n  <= strb_d.we_n;
         oe_n  <= strb_d.oe_n;
         dq_oe <= strb_d.dq_oe;
         ready <= strb_d.ready;
      end
   end
endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
   parameter int ADDR_W         = 15,
   parameter int DATA_W         = 8,
   parameter int CNT_W          = 6,
   parameter bit HOLD_IDLE_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [CNT_W-1:0]  cfg_cycle,
   input  logic [CNT_W-1:0]  cfg_oe,
   input  logic              capture,
   input  logic              standby,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              write_q,
   output logic [CNT_W-1:0]  n_q,
   output logic [CNT_W-1:0]  k_q,
   output logic [CNT_W-1:0]  l_q,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [CNT_W-1:0]  n_c, k_c;

   assign n_c = (cfg_cycle == '0) ? ONE : cfg_cycle;
   assign k_c = (cfg_oe == '0)    ? ONE : cfg_oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         write_q <= 1'b0;
         n_q     <= ONE;
         k_q     <= ONE;
         l_q     <= ONE;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         write_q <= req_write;
         n_q     <= n_c;
         k_q     <= k_c;
         l_q     <= (k_c > n_c) ? k_c : n_c;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= capture;
         if (capture) rd_data <= mem_dq_in;
      end
   end

   assign mem_dq_out = wdata_q;

   generate
      if (HOLD_IDLE_ADDR) begin : g_addr_hold
         assign mem_addr = addr_q;
      end else begin : g_addr_zero
         assign mem_addr = standby ? '0 : addr_q;
      end
   endgenerate
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
   parameter int ADDR_W         = 15,
   parameter int DATA_W         = 8,
   parameter int CNT_W          = 6,
   parameter bit HOLD_IDLE_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [CNT_W-1:0]  cfg_cycle,
   input  logic [CNT_W-1:0]  cfg_oe,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("asram_ctrl: ADDR_W must lie in 1..32");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("asram_ctrl: DATA_W must be at least 1");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("asram_ctrl: CNT_W must lie in 2..16");
      end
   endgenerate

   logic             accept, tmr_start, tmr_run, capture, write_q;
   logic [CNT_W-1:0] n_q, k_q, l_q, elapsed;

   asram_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tmr_start),
      .run     (tmr_run),
      .elapsed (elapsed)
   );

   asram_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .write_q   (write_q),
      .n_q       (n_q),
      .k_q       (k_q),
      .l_q       (l_q),
      .elapsed   (elapsed),
      .accept    (accept),
      .tmr_start (tmr_start),
      .tmr_run   (tmr_run),
      .capture   (capture),
      .ce_n      (mem_ce_n),
      .we_n      (mem_we_n),
      .oe_n      (mem_oe_n),
      .dq_oe     (mem_dq_oe),
      .ready     (req_ready)
   );

   asram_dpath #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .CNT_W          (CNT_W),
      .HOLD_IDLE_ADDR (HOLD_IDLE_ADDR)
   ) u_dpath (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .cfg_cycle  (cfg_cycle),
      .cfg_oe     (cfg_oe),
      .capture    (capture),
      .standby    (mem_ce_n),
      .mem_dq_in  (mem_dq_in),
      .write_q    (write_q),
      .n_q        (n_q),
      .k_q        (k_q),
      .l_q        (l_q),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data)
   );
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rd_valid,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);
   AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready); // R2
   AST_NO_WE_OE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n)); // R7
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n); // R7
   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> $past(mem_oe_n)); // R7
   AST_WE_RISE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_we_n) && !mem_ce_n) |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr))); // R8
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R8
   AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R6
   AST_RDV_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!mem_oe_n)); // R6
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rd_valid   (rd_valid),
   .mem_ce_n   (mem_ce_n),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_addr   (mem_addr),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 15;
   localparam int DW = 8;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [CW-1:0] cfg_cycle = 6'd1;
   logic [CW-1:0] cfg_oe = 6'd1;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_out, mem_dq_in;

   int n_checks = 0;
   int n_fail = 0;
   logic [DW-1:0] model [256];
   logic [DW-1:0] shadow [256];
   logic [DW-1:0] oe_ph = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   asram_ctrl u_asram_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .cfg_cycle(cfg_cycle), .cfg_oe(cfg_oe), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   // Memory model: the returned byte mixes in clocks since output enable fell
   always_ff @(posedge clk) begin
      if (mem_oe_n) oe_ph <= '0;
      else          oe_ph <= oe_ph + 8'd1;
   end
   assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? (model[mem_addr[7:0]] ^ oe_ph) : 8'hEE;
   always @(posedge mem_we_n) begin
      if (rst_n && !mem_ce_n && mem_dq_oe) model[mem_addr[7:0]] <= mem_dq_out;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         model[i]  = 8'(i) ^ 8'h5A;
         shadow[i] = 8'(i) ^ 8'h5A;
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(mem_ce_n === 1'b1, req, "ce_n idle", mem_ce_n, 1);
      chk(mem_we_n === 1'b1, req, "we_n idle", mem_we_n, 1);
      chk(mem_oe_n === 1'b1, req, "oe_n idle", mem_oe_n, 1);
      chk(mem_dq_oe === 1'b0, req, "dq_oe idle", mem_dq_oe, 0);
      chk(req_ready === 1'b1, req, "ready idle", req_ready, 1);
   endtask

   task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int n, input int k);
      @(negedge clk);
      chk(req_ready === 1'b1, "R2", "ready before request", req_ready, 1);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      cfg_cycle = CW'(n); cfg_oe = CW'(k);
      @(negedge clk);
      req_valid = 1'b0;
      // setup clock
      chk(mem_ce_n === 1'b0 && mem_we_n === 1'b1 && mem_oe_n === 1'b1 && mem_dq_oe === 1'b0,
          "R3", "setup strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0110);
      chk(req_ready === 1'b0, "R2", "ready low in access", req_ready, 0);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int n,
                           input bit disturb);
      int neff;
      neff = (n == 0) ? 1 : n;
      issue(1'b1, a, d, n, 1);
      for (int i = 0; i < neff; i++) begin
         @(negedge clk);
         if (disturb) begin
            req_valid = 1'b1; req_addr = ~a; req_wdata = ~d; cfg_cycle = 6'd9;
         end
         chk(mem_ce_n === 1'b0 && mem_we_n === 1'b0 && mem_dq_oe === 1'b1 && mem_oe_n === 1'b1,
             "R4", "write pulse strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0011);
         chk(mem_addr === a && mem_dq_out === d, "R8", "addr/data held in write",
             {mem_addr, mem_dq_out}, {a, d});
      end
      @(negedge clk);
      chk(mem_ce_n === 1'b0 && mem_we_n === 1'b1 && mem_dq_oe === 1'b1 && mem_dq_out === d,
          "R4", "write hold clock", {mem_ce_n, mem_we_n, mem_dq_oe, mem_dq_out}, {3'b011, d});
      @(negedge clk);
      req_valid = 1'b0;
      chk_idle("R1");
      chk(mem_addr === a, "R9", "idle address held", mem_addr, a);
      shadow[a[7:0]] = d;
      chk(model[a[7:0]] === d, "R4", "memory committed", model[a[7:0]], d);
      if (disturb) begin
         @(negedge clk);
         chk(mem_ce_n === 1'b1, "R2", "no access without valid", mem_ce_n, 1);
      end
   endtask

   task automatic do_read(input logic [AW-1:0] a, input int n, input int k);
      int neff, keff, len;
      logic [DW-1:0] exp;
      neff = (n == 0) ? 1 : n;
      keff = (k == 0) ? 1 : k;
      len  = (keff > neff) ? keff : neff;
      exp  = shadow[a[7:0]] ^ 8'(keff - 1);
      issue(1'b0, a, 8'h00, n, k);
      for (int i = 1; i <= len; i++) begin
         @(negedge clk);
         chk(mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1 && mem_dq_oe === 1'b0,
             "R5", "read strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0100);
         chk(mem_addr === a, "R8", "addr held in read", mem_addr, a);
         chk(rd_valid === (i == keff + 1), "R6", "rd_valid timing", rd_valid, (i == keff + 1));
         if (i == keff + 1) chk(rd_data === exp, "R6", "read data", rd_data, exp);
      end
      @(negedge clk);
      chk_idle("R5");
      chk(rd_valid === (keff == len), "R6", "rd_valid at end", rd_valid, (keff == len));
      if (keff == len) chk(rd_data === exp, "R6", "read data at end", rd_data, exp);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk_idle("R1");
      chk(rd_valid === 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1");
   endtask

   task automatic t_write_read();
      do_write(15'h0012, 8'hA7, 3, 1'b0);
      do_read(15'h0012, 4, 2);
      do_read(15'h0033, 3, 3);
   endtask

   task automatic t_long_oe();
      do_read(15'h0040, 2, 5);
   endtask

   task automatic t_zero_counts();
      do_write(15'h0007, 8'h3C, 0, 1'b0);
      do_read(15'h0007, 0, 0);
   endtask

   task automatic t_turnaround();
      do_read(15'h0050, 2, 1);
      do_write(15'h0051, 8'hC3, 2, 1'b0);
      do_read(15'h0051, 1, 4);
   endtask

   task automatic t_busy_ignored();
      do_write(15'h1AAA, 8'h96, 4, 1'b1);
      do_read(15'h1AAA, 2, 2);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      t_reset();
      t_write_read();
      t_long_oe();
      t_zero_counts();
      t_turnaround();
      t_busy_ignored();
      repeat (2) @(negedge clk);
      summary();
   end
endmodule